// File: doc/BRIEF.md
# Character Pixel Attribute Mixer

This block decides, one pixel at a time, which video source an overlay output stage should show. Its inputs are the glyph pixel code for the character under the beam and that character's three attribute bits: local background, blink and invert. It returns a 2-bit source select (black, white, live video or flat background level) and the 3-bit background brightness code that goes with it. The select is registered, so it appears one clock after the inputs.

A sync-mode input says whether live video is present. With live video, background pixels may either pass the video through or show the flat level, depending on the local background bit. Without live video, the local background bit is treated as set, so the video source is never chosen. The block also keeps a blink phase. A frame counter advances on a frame strobe. Its period and on:off ratio are picked by two small codes. While a blinking character is in its off phase, the whole character cell is replaced by video or by background, depending on the sync mode.

Top module: `char_pixel_mixer`

## Requirements
- R1: While rst_ni is low, sel_o is 00, level_o is 0, the frame counter is 0 and blink_on_o is 1.
- R2: Glyph codes are 00 black, 01 white, and 10 or 11 transparent. With invert 0 and no blink-off replacement, black gives sel_o 00 and white gives sel_o 01.
- R3: With invert 1, a black glyph pixel gives sel_o 01 and a white glyph pixel gives sel_o 00. Transparent pixels are not affected by invert.
- R4: A transparent pixel with ext_sync_i 1 and local background bit 0 gives sel_o 10 (video input).
- R5: A transparent pixel with the local background bit 1 gives sel_o 11 (background level) in either sync mode. With ext_sync_i 0 the bit is treated as 1, so sel_o is never 10.
- R6: With blink attribute 1 and blink_on_o 0, sel_o is 10 when ext_sync_i is 1 and 11 when it is 0, for any glyph code and invert value. With blink attribute 0 the blink phase has no effect.
- R7: The frame counter advances by one on each cycle with frame_start_i high. It has period P = 8 << blink_rate_i frames (8, 16, 32, 64) and wraps to 0 after P-1. If the counter is at or beyond P-1 when the rate changes, the next frame strobe sets it to 0.
- R8: blink_on_o is 1 when the counter value is below an on-length L. L is floor(P/2), floor(P/3), floor(P/4) or P-floor(P/4) for blink_duty_i codes 0, 1, 2 and 3.
- R9: sel_o and level_o are registered. The values seen after a rising edge are computed from the inputs and the blink phase at that edge, and level_o equals bg_level_i from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle strobe, once per frame |
| blink_rate_i | input | 2 | Blink period code |
| blink_duty_i | input | 2 | Blink on:off ratio code |
| ext_sync_i | input | 1 | 1: live video present, 0: internal timing |
| bg_level_i | input | 3 | Background brightness code |
| glyph_pix_i | input | 2 | Glyph pixel code |
| attr_lbc_i | input | 1 | Local background bit of the character |
| attr_blink_i | input | 1 | Blink enable bit of the character |
| attr_inv_i | input | 1 | Invert bit of the character |
| sel_o | output | 2 | Source select: 00 black, 01 white, 10 video, 11 background |
| level_o | output | 3 | Registered background brightness code |
| blink_on_o | output | 1 | Current blink phase, 1 = character shown |

## Verification
The pixel decision is swept over every combination of glyph code, invert, local background, blink attribute and sync mode. The sweep runs once in an on phase and once in an off phase, with a changing brightness code. This separates the invert path, the two background sources, the forced background under internal sync, and the blink replacement that overrides the glyph. The blink timer is walked through two full periods for all sixteen rate and duty pairs, so every on-length boundary and every wrap point is compared. A reset in the middle of a run and a rate drop with the counter past the new period check that the counter recovers to 0.

// File: rtl/mixer_pkg.sv
package mixer_pkg;
  typedef enum logic [1:0] {
    SEL_BLACK = 2'b00,
    SEL_WHITE = 2'b01,
    SEL_VIDEO = 2'b10,
    SEL_BG    = 2'b11
  } vsel_e;

  localparam logic [1:0] GLYPH_BLACK = 2'b00;
  localparam logic [1:0] GLYPH_WHITE = 2'b01;
  localparam int GLYPH_TRANSP_BIT = 1;
endpackage

// File: rtl/blink_timer.sv
module blink_timer #(
  parameter int RATE_W    = 2,
  parameter int BASE_LOG2 = 3,
  localparam int CNT_W    = BASE_LOG2 + (1 << RATE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [1:0]        duty_i,
  output logic              blink_on_o
);
  localparam int PW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    period, on_len, cnt_ext;
  logic             at_end;

  assign period  = PW'(1) << (BASE_LOG2 + int'(rate_i));
  assign cnt_ext = PW'(cnt_q);
  assign at_end  = cnt_ext >= (period - PW'(1));

  always_comb begin
    unique case (duty_i)
      2'd0:    on_len = period >> 1;
      2'd1:    on_len = period / PW'(3);
      2'd2:    on_len = period >> 2;
      default: on_len = period - (period >> 2);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (frame_start_i) cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
  end

  assign blink_on_o = cnt_ext < on_len;

  p_cnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (cnt_q == '0 || cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(cnt_q));
endmodule

// File: rtl/pixel_select.sv
module pixel_select
  import mixer_pkg::*;
(
  input  logic [1:0] glyph_i,
  input  logic       inv_i,
  input  logic       lbc_i,
  input  logic       blink_i,
  input  logic       ext_sync_i,
  input  logic       blink_on_i,
  output vsel_e      sel_o
);
  logic  lbc_eff, transp, hide;
  vsel_e bg_src;

  assign lbc_eff = lbc_i | ~ext_sync_i;   // internal sync forces local bg
  assign transp  = glyph_i[GLYPH_TRANSP_BIT];
  assign hide    = blink_i & ~blink_on_i;
  assign bg_src  = lbc_eff ? SEL_BG : SEL_VIDEO;

  always_comb begin
    if (hide)        sel_o = ext_sync_i ? SEL_VIDEO : SEL_BG;
    else if (transp) sel_o = bg_src;
    else if ((glyph_i == GLYPH_WHITE) ^ inv_i) sel_o = SEL_WHITE;
    else             sel_o = SEL_BLACK;
  end

  always_comb begin
    if (!ext_sync_i) a_no_video_int_r5: assert (sel_o != SEL_VIDEO);
  end
endmodule

// File: rtl/char_pixel_mixer.sv
module char_pixel_mixer
  import mixer_pkg::*;
#(
  parameter int RATE_W    = 2,
  parameter int BASE_LOG2 = 3,
  parameter int LEVEL_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic [RATE_W-1:0]  blink_rate_i,
  input  logic [1:0]         blink_duty_i,
  input  logic               ext_sync_i,
  input  logic [LEVEL_W-1:0] bg_level_i,
  input  logic [1:0]         glyph_pix_i,
  input  logic               attr_lbc_i,
  input  logic               attr_blink_i,
  input  logic               attr_inv_i,
  output logic [1:0]         sel_o,
  output logic [LEVEL_W-1:0] level_o,
  output logic               blink_on_o
);
  logic  blink_on;
  vsel_e sel_d;

  blink_timer #(.RATE_W(RATE_W), .BASE_LOG2(BASE_LOG2)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .rate_i       (blink_rate_i),
    .duty_i       (blink_duty_i),
    .blink_on_o   (blink_on)
  );

  pixel_select u_sel (
    .glyph_i   (glyph_pix_i),
    .inv_i     (attr_inv_i),
    .lbc_i     (attr_lbc_i),
    .blink_i   (attr_blink_i),
    .ext_sync_i(ext_sync_i),
    .blink_on_i(blink_on),
    .sel_o     (sel_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= SEL_BLACK;
      level_o <= '0;
    end else begin
      sel_o   <= sel_d;
      level_o <= bg_level_i;
    end
  end

  assign blink_on_o = blink_on;

  p_int_sync_no_video_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_sync_i |=> sel_o != SEL_VIDEO);

  p_invert_black_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attr_inv_i && glyph_pix_i == GLYPH_BLACK && !(attr_blink_i && !blink_on))
      |=> sel_o == SEL_WHITE);

  p_blink_off_ext_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attr_blink_i && !blink_on && ext_sync_i) |=> sel_o == SEL_VIDEO);

  p_level_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> level_o == $past(bg_level_i));
endmodule

// File: tb/char_pixel_mixer_tb_top.sv
module char_pixel_mixer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_start = 1'b0;
  logic [1:0] rate = 2'd0, duty = 2'd0;
  logic       ext_sync = 1'b1;
  logic [2:0] bg_level = 3'd0;
  logic [1:0] glyph = 2'd0;
  logic       lbc = 1'b0, blk = 1'b0, inv = 1'b0;
  logic [1:0] sel;
  logic [2:0] level;
  logic       blink_on;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  char_pixel_mixer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start),
    .blink_rate_i(rate), .blink_duty_i(duty), .ext_sync_i(ext_sync),
    .bg_level_i(bg_level), .glyph_pix_i(glyph), .attr_lbc_i(lbc),
    .attr_blink_i(blk), .attr_inv_i(inv), .sel_o(sel), .level_o(level),
    .blink_on_o(blink_on)
  );

  task automatic check(int act, int exp, string req);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic int model_sel(int g, int i, int l, int b, int e, int on);
    int lb;
    lb = l | (e == 0 ? 1 : 0);
    if (b == 1 && on == 0) return (e == 1) ? 2 : 3;   // R6
    if (g >= 2) return (lb == 1) ? 3 : 2;             // R4 R5
    return g ^ i;                                     // R2 R3
  endfunction

  function automatic int on_len(int r, int d);
    int p;
    p = 8 << r;
    case (d)
      0: return p / 2;
      1: return p / 3;
      2: return p / 4;
      default: return p - p / 4;
    endcase
  endfunction

  task automatic pulse_frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic sweep_pixels(int on);
    int idx;
    idx = 0;
    for (int e = 0; e < 2; e++)
      for (int b = 0; b < 2; b++)
        for (int l = 0; l < 2; l++)
          for (int i = 0; i < 2; i++)
            for (int g = 0; g < 4; g++) begin
              ext_sync = e[0]; blk = b[0]; lbc = l[0]; inv = i[0];
              glyph = g[1:0]; bg_level = idx[2:0];
              @(negedge clk);
              check(int'(sel), model_sel(g, i, l, b, e, on),
                    (b == 1 && on == 0) ? "R6" : (g >= 2) ? (l == 1 || e == 0 ? "R5" : "R4")
                                                     : (i == 1 ? "R3" : "R2"));
              check(int'(level), idx % 8, "R9");
              idx++;
            end
  endtask

  initial begin
    #1;
    check(int'(sel), 0, "R1");
    check(int'(level), 0, "R1");
    check(int'(blink_on), 1, "R1");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // rate 0 duty 0: P=8, L=4
    sweep_pixels(1);
    repeat (4) pulse_frame();
    check(int'(blink_on), 0, "R8");
    sweep_pixels(0);

    // blink attribute 0 ignores phase off: R6
    blk = 1'b0; ext_sync = 1'b1; lbc = 1'b0; inv = 1'b0; glyph = 2'd1;
    @(negedge clk);
    check(int'(sel), 1, "R6");

    // timer walk: R7 R8
    for (int r = 0; r < 4; r++)
      for (int d = 0; d < 4; d++) begin
        rate = r[1:0]; duty = d[1:0];
        do_reset();
        for (int k = 0; k < 2 * (8 << r); k++) begin
          check(int'(blink_on), ((k % (8 << r)) < on_len(r, d)) ? 1 : 0,
                (k % (8 << r)) == 0 ? "R7" : "R8");
          pulse_frame();
        end
      end

    // rate drop past new period wraps on next strobe: R7
    rate = 2'd3; duty = 2'd0;
    do_reset();
    repeat (40) pulse_frame();
    check(int'(blink_on), 0, "R7");
    rate = 2'd0;
    @(negedge clk);
    check(int'(blink_on), 0, "R7");
    pulse_frame();
    check(int'(blink_on), 1, "R7");
    repeat (3) pulse_frame();
    check(int'(blink_on), 1, "R7");
    pulse_frame();
    check(int'(blink_on), 0, "R7");

    // mid-run reset: R1
    glyph = 2'd1; bg_level = 3'd5; blk = 1'b0;
    @(negedge clk);
    check(int'(sel), 1, "R9");
    rst_ni = 1'b0;
    #1;
    check(int'(sel), 0, "R1");
    check(int'(level), 0, "R1");
    check(int'(blink_on), 1, "R1");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule